// File: doc/BRIEF.md
# Fractional Clock Divider with Overflow-Steered Dual Modulus

This block divides a fast input clock by a ratio that may lie between two integers. A down-counter produces one output pulse per division cycle. Each cycle lasts either `n` or `n+1` input clocks. A `k`-bit phase register chooses between the two lengths. It advances by the fractional word once per output pulse. When the register wraps past its top value, the following division cycle is one input clock longer. As a result, the mean division ratio equals `n + i/2^k`.

The block is meant to sit in the feedback path of a frequency synthesizer, where the output pulse acts as the divided-down feedback edge. The modulus-select output shows which length the current cycle uses. The integer and fractional settings are sampled only at a cycle boundary, so a cycle is never resized partway through. A wider phase register gives a finer step in the achievable ratio.

Top module: `frac_divider`

## Requirements
- R1: While `rst` is high at a rising edge, the phase register and `mod_sel` clear to zero and the counter is loaded so the first division cycle uses modulus `n` with no extension; with reset released, the first `div_pulse` appears after exactly `n-1` rising edges.
- R2: `div_pulse` is high for exactly one input clock per division cycle (for `n >= 2`), and successive pulses are spaced either `n` or `n+1` input clocks apart.
- R3: The phase register changes only on the edge that ends a division cycle, where it takes `(A + i) mod 2^k`; between pulses it holds its value.
- R4: When `A + i` exceeds `2^k - 1` at a pulse, the division cycle that begins at that edge lasts `n+1` clocks and `mod_sel` is 1 throughout it. Otherwise that cycle lasts `n` clocks and `mod_sel` is 0.
- R5: With `i = 0` every division cycle lasts `n` clocks and `mod_sel` stays 0.
- R6: Starting from reset, the `2^k` division cycles that follow the first pulse total exactly `n*2^k + i` input clocks.
- R7: A change to `n` or `i` in the middle of a division cycle leaves that cycle's length unchanged. It takes effect from the next boundary onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| mod_int | input | INT_W | Base integer modulus `n` (2 or more) |
| frac_word | input | FRAC_W | Fractional word `i`, step added per output pulse |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| mod_sel | output | 1 | 1 while the current cycle uses modulus `n+1` |

## Verification
The edge that ends a division cycle does two things at once. It reloads the counter and it adds the fractional word to the phase register, and the wrap from that addition must lengthen the very cycle being loaded. The bench provokes this coincidence on every pulse, using fractional words of 1, half scale and full scale minus one, so that wraps are rare, alternating and almost constant. An independent phase model predicts the length of each cycle and the value of `mod_sel`, and the bench also compares the total clock count over `2^k` cycles with `n*2^k + i`. A second test changes the modulus partway through a cycle. It checks that the cycle then running keeps its old length and that the next cycle takes the new one.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } mod_kind_e;
endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q,
  output logic             wrap
);
  localparam int SUM_W = ACC_W + 1;

  function automatic logic [SUM_W-1:0] acc_sum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [SUM_W-1:0] sum_w;
  assign sum_w = acc_sum(acc_q, step);
  assign wrap  = sum_w[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (step_en) acc_q <= sum_w[ACC_W-1:0];
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(acc_q)); // R3
  AST_WRAP_DROPS: assert property (@(posedge clk) disable iff (rst)
    (step_en && wrap) |=> (acc_q < $past(acc_q))); // R3
endmodule

// File: rtl/dual_mod_counter.sv
module dual_mod_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] base_mod,
  input  logic             plus_one,
  output logic             term
);
  function automatic logic [CNT_W-1:0] reload_val(input logic [CNT_W-1:0] m,
                                                  input logic ext);
    logic [CNT_W:0] t;
    t = {1'b0, m} + {{CNT_W{1'b0}}, ext} - 1'b1;
    return t[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] cnt_q;
  assign term = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= reload_val(base_mod, 1'b0);
    else if (term) cnt_q <= reload_val(base_mod, plus_one);
    else cnt_q <= cnt_q - 1'b1;
  end

  AST_PULSE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (term && base_mod >= 2 && $stable(base_mod)) |=> !term); // R2
endmodule

// File: rtl/frac_divider.sv
module frac_divider #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  mod_int,
  input  logic [FRAC_W-1:0] frac_word,
  output logic              div_pulse,
  output logic              mod_sel
);
  import fdiv_pkg::*;

  logic              tick;
  logic              wrap;
  logic [FRAC_W-1:0] phase;
  mod_kind_e         kind_q;

  dual_mod_counter #(.CNT_W(INT_W)) u_cnt (
    .clk(clk), .rst(rst), .base_mod(mod_int),
    .plus_one(wrap), .term(tick)
  );

  phase_accum #(.ACC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .step_en(tick), .step(frac_word),
    .acc_q(phase), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) kind_q <= MOD_BASE;
    else if (tick) kind_q <= wrap ? MOD_PLUS : MOD_BASE;
  end

  assign div_pulse = tick;
  assign mod_sel   = (kind_q == MOD_PLUS);

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(mod_sel)); // R4
  AST_WRAP_EXTENDS: assert property (@(posedge clk) disable iff (rst)
    (tick && wrap) |=> mod_sel); // R4
  AST_ZERO_NO_EXT: assert property (@(posedge clk) disable iff (rst)
    (tick && frac_word == '0) |=> !mod_sel); // R5
endmodule

// File: tb/frac_divider_test.sv
module frac_divider_test;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 6;
  localparam int FULL   = 1 << FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [INT_W-1:0]  mod_int = 8'd5;
  logic [FRAC_W-1:0] frac_word = '0;
  logic div_pulse, mod_sel;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  frac_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst(rst), .mod_int(mod_int), .frac_word(frac_word),
    .div_pulse(div_pulse), .mod_sel(mod_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reset, then wait for the first pulse; R1
  task automatic start(input int n, input int i);
    int edges = 0;
    @(negedge clk);
    rst = 1'b1; mod_int = INT_W'(n); frac_word = FRAC_W'(i);
    repeat (2) @(negedge clk);
    check(mod_sel == 1'b0, "R1 mod_sel in reset", mod_sel, 0);
    rst = 1'b0;
    while (!div_pulse && edges < 1000) begin
      @(posedge clk); #1; edges++;
    end
    check(edges == n - 1, "R1 first pulse edges", edges, n - 1);
  endtask

  // measure one cycle from the current pulse to the next; returns length and mod_sel
  task automatic one_cycle(output int len, output int sel);
    len = 0; sel = 0;
    do begin
      @(posedge clk); #1; len++;
      if (len == 1) begin
        sel = int'(mod_sel);
        check(!div_pulse, "R2 pulse width", int'(div_pulse), 0);
      end
    end while (!div_pulse && len < 1000);
  endtask

  task automatic run_pattern(input int n, input int i);
    int acc_m = 0;
    int sum = 0;
    int len, sel, ext;
    start(n, i);
    for (int p = 0; p < FULL; p++) begin
      acc_m = acc_m + i;
      ext = (acc_m >= FULL) ? 1 : 0;
      if (ext == 1) acc_m = acc_m - FULL;
      one_cycle(len, sel);
      sum += len;
      check(len == n + ext, (i == 0) ? "R5 cycle length" : "R4 cycle length", len, n + ext);
      check(sel == ext, (i == 0) ? "R5 mod_sel" : "R4 mod_sel", sel, ext);
      check(len == n || len == n + 1, "R2 spacing", len, n);
    end
    check(sum == n * FULL + i, "R6 total clocks", sum, n * FULL + i);
    // R3: the phase returns to its start after 2^k steps, so the pattern repeats
    acc_m = acc_m + i;
    ext = (acc_m >= FULL) ? 1 : 0;
    one_cycle(len, sel);
    check(len == n + ext, "R3 phase wrap repeat", len, n + ext);
  endtask

  task automatic test_midchange();
    int len, sel;
    start(5, 0);
    @(posedge clk); #1;
    mod_int = 8'd9;
    len = 1;
    while (!div_pulse && len < 1000) begin
      @(posedge clk); #1; len++;
    end
    check(len == 5, "R7 running cycle kept", len, 5);
    one_cycle(len, sel);
    check(len == 9, "R7 next cycle new n", len, 9);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_pattern(5, 0);
    run_pattern(4, 1);
    run_pattern(6, FULL / 2);
    run_pattern(3, FULL - 1);
    run_pattern(7, 23);
    test_midchange();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule